// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block receives configuration words for a frequency synthesizer over three wires: a serial clock, a serial data line and a strobe. While the strobe is low, data bits are shifted in on rising serial-clock edges, least significant bit first. When the strobe goes high, the block uses the number of bits received and the address bits at the top of the word to decide which working register the word is for. It then loads that register, or discards the word.

There are five working registers. The A register holds the main-divider setting. B, C, D and E hold the other configuration fields. An A word is not applied when the strobe rises. It is held, and it is committed only while the divider's synchronization input is high during the strobe-high window, so that the divider never sees a mid-count change. From the moment an A word is accepted until the strobe falls, the block requests speed-up of the loop's charge pumps. A flag held in the D register selects whether A words are 24 or 32 bits long. The operating mode and the test-routing enable are decoded from the C and E registers.

All three serial inputs pass through two-flop synchronizers into the system clock domain, and edges on them are detected in that domain. The serial clock must therefore run several times slower than the system clock.

Top module: `synth_prog_if`

## Requirements
- R1: Bits are shifted in on synchronized rising edges of ser_clk while ser_strobe is low. The first bit received becomes bit 0 of the word.
- R2: A 24-bit word whose top four bits (23..20) are 1000, 1001, 1010 or 1111 loads its bits 19..0 into b_fields, c_fields, d_fields or e_fields respectively, when the strobe rises.
- R3: When long_mode is 0, a 24-bit word with bit 23 equal to 0 is an A word. Its bits 22..0, zero-extended, become the pending A value.
- R4: long_mode equals bit 19 of d_fields. When it is 1, an A word is 32 bits with bit 31 equal to 0, its bits 30..0 are the pending A value, and a 24-bit word with bit 23 equal to 0 is discarded.
- R5: A pending A value is copied to a_fields only on cycles where div_sync is high and the strobe is still high. If the strobe falls with no such cycle, a_fields keeps its old value.
- R6: speed_up goes high within four clock cycles after the strobe rises on an accepted A word, and returns low within four cycles after the strobe falls. Other words never raise it.
- R7: op_mode equals bits 1..0 of c_fields, where 00 selects emulation mode and 01 selects extended mode.
- R8: test_route is high exactly when bits 1..0 of e_fields are 11.
- R9: A word with an undefined address (top four bits not one of the four listed in R2), or with a bit count other than 24 or 32, changes no register.
- R10: After reset, all field outputs, op_mode, long_mode, test_route and speed_up are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_strobe | input | 1 | Low: shift; high: transfer word |
| div_sync | input | 1 | Main-divider synchronization window, clk domain |
| a_fields | output | 31 | Committed main-divider word payload |
| b_fields | output | 20 | B register payload |
| c_fields | output | 20 | C register payload |
| d_fields | output | 20 | D register payload |
| e_fields | output | 20 | E register payload |
| op_mode | output | 2 | Operating mode from C bits 1..0 |
| long_mode | output | 1 | A-word length select from D bit 19 |
| test_route | output | 1 | Test routing enable from E bits 1..0 |
| speed_up | output | 1 | Speed-up request during an A-word strobe |

## Verification
A wrong bit count or a misaligned shift register shows up at the ports on the next strobe: the wrong register loads, or a field appears shifted by one bit. A corrupted long-mode flag makes A words of one length load when they should be discarded, or the reverse, and this is also visible right after the next strobe. A faulty sync gate moves a_fields during a strobe window with div_sync low, or leaves it unchanged after a window that had one. A stuck speed-up state is visible within four cycles of either strobe edge.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int SHORT_LEN = 24;
  localparam int LONG_LEN  = 32;
  localparam int ADDR_W    = 4;
  localparam int PAY_W     = SHORT_LEN - ADDR_W;
  localparam int A_W       = LONG_LEN - 1;
  localparam int CNT_W     = $clog2(LONG_LEN + 2);

  localparam logic [ADDR_W-1:0] ADR_B = 4'b1000;
  localparam logic [ADDR_W-1:0] ADR_C = 4'b1001;
  localparam logic [ADDR_W-1:0] ADR_D = 4'b1010;
  localparam logic [ADDR_W-1:0] ADR_E = 4'b1111;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_A,
    SEL_B,
    SEL_C,
    SEL_D,
    SEL_E
  } sel_e;
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], din[i]};
    end
    assign dout[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/synth_prog_shift.sv
module synth_prog_shift #(
  parameter int LEN = 32,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sdat_s,
  input  logic          stb_s,
  output logic [LEN-1:0] sr,
  output logic [CW-1:0]  cnt,
  output logic           stb_rise,
  output logic           stb_fall
);
  localparam logic [CW-1:0] CAP = CW'(LEN + 1);

  logic sclk_q, stb_q, sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign stb_rise  = stb_s & ~stb_q;
  assign stb_fall  = ~stb_s & stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      stb_q  <= stb_s;
      if (stb_fall) begin
        cnt <= '0;
      end else if (!stb_s && sclk_rise) begin
        // first bit in ends up at the lowest position after the last shift
        sr <= {sdat_s, sr[LEN-1:1]};
        if (cnt != CAP) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_prog_decode.sv
module synth_prog_decode
  import synth_prog_pkg::*;
(
  input  logic [LONG_LEN-1:0] sr,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                long_mode,
  output sel_e                sel,
  output logic [A_W-1:0]      payload
);
  logic [SHORT_LEN-1:0] w24;
  assign w24 = sr[LONG_LEN-1 -: SHORT_LEN];

  always_comb begin
    sel     = SEL_NONE;
    payload = '0;
    if (cnt == CNT_W'(SHORT_LEN)) begin
      if (!w24[SHORT_LEN-1]) begin
        if (!long_mode) begin
          sel     = SEL_A;
          payload = A_W'(w24[SHORT_LEN-2:0]);
        end
      end else begin
        payload = A_W'(w24[PAY_W-1:0]);
        case (w24[SHORT_LEN-1 -: ADDR_W])
          ADR_B:   sel = SEL_B;
          ADR_C:   sel = SEL_C;
          ADR_D:   sel = SEL_D;
          ADR_E:   sel = SEL_E;
          default: sel = SEL_NONE;
        endcase
      end
    end else if (cnt == CNT_W'(LONG_LEN) && long_mode && !sr[LONG_LEN-1]) begin
      sel     = SEL_A;
      payload = sr[A_W-1:0];
    end
  end
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_rise,
  input  logic             stb_fall,
  input  sel_e             sel,
  input  logic [A_W-1:0]   payload,
  input  logic             div_sync,
  output logic [A_W-1:0]   a_fields,
  output logic [PAY_W-1:0] b_fields,
  output logic [PAY_W-1:0] c_fields,
  output logic [PAY_W-1:0] d_fields,
  output logic [PAY_W-1:0] e_fields,
  output logic             speed_up
);
  logic [A_W-1:0] a_hold;
  logic           a_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold   <= '0;
      a_live   <= 1'b0;
      a_fields <= '0;
      b_fields <= '0;
      c_fields <= '0;
      d_fields <= '0;
      e_fields <= '0;
    end else begin
      if (stb_rise) begin
        case (sel)
          SEL_A: begin
            a_hold <= payload;
            a_live <= 1'b1;
          end
          SEL_B:   b_fields <= payload[PAY_W-1:0];
          SEL_C:   c_fields <= payload[PAY_W-1:0];
          SEL_D:   d_fields <= payload[PAY_W-1:0];
          SEL_E:   e_fields <= payload[PAY_W-1:0];
          default: ;
        endcase
      end
      if (stb_fall)                 a_live   <= 1'b0;
      else if (a_live && div_sync)  a_fields <= a_hold;
    end
  end

  assign speed_up = a_live;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LONG_BIT    = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_strobe,
  input  logic             div_sync,
  output logic [A_W-1:0]   a_fields,
  output logic [PAY_W-1:0] b_fields,
  output logic [PAY_W-1:0] c_fields,
  output logic [PAY_W-1:0] d_fields,
  output logic [PAY_W-1:0] e_fields,
  output logic [1:0]       op_mode,
  output logic             long_mode,
  output logic             test_route,
  output logic             speed_up
);
  logic [2:0]          pins_s;
  logic [LONG_LEN-1:0] sr;
  logic [CNT_W-1:0]    cnt;
  logic                stb_rise, stb_fall;
  sel_e                sel;
  logic [A_W-1:0]      payload;

  synth_prog_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({ser_strobe, ser_data, ser_clk}),
    .dout(pins_s)
  );

  synth_prog_shift #(.LEN(LONG_LEN), .CW(CNT_W)) u_shift (
    .clk (clk), .rst_n (rst_n),
    .sclk_s(pins_s[0]), .sdat_s(pins_s[1]), .stb_s(pins_s[2]),
    .sr (sr), .cnt (cnt), .stb_rise(stb_rise), .stb_fall(stb_fall)
  );

  synth_prog_decode u_dec (
    .sr (sr), .cnt (cnt), .long_mode(long_mode),
    .sel(sel), .payload(payload)
  );

  synth_prog_regs u_regs (
    .clk (clk), .rst_n (rst_n),
    .stb_rise(stb_rise), .stb_fall(stb_fall),
    .sel (sel), .payload(payload), .div_sync(div_sync),
    .a_fields(a_fields), .b_fields(b_fields), .c_fields(c_fields),
    .d_fields(d_fields), .e_fields(e_fields), .speed_up(speed_up)
  );

  assign op_mode    = c_fields[1:0];
  assign long_mode  = d_fields[LONG_BIT];
  assign test_route = (e_fields[1:0] == 2'b11);
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             div_sync,
  input logic             stb_rise,
  input logic             stb_fall,
  input logic [CNT_W-1:0] cnt,
  input logic [A_W-1:0]   a_fields,
  input logic [PAY_W-1:0] b_fields,
  input logic [PAY_W-1:0] c_fields,
  input logic [PAY_W-1:0] d_fields,
  input logic [PAY_W-1:0] e_fields,
  input logic [1:0]       op_mode,
  input logic             speed_up
);
  // R5: the A field only moves on a cycle with sync and an open A window
  p_a_needs_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a_fields) |-> ($past(div_sync) && $past(speed_up)));

  // R6: speed-up is released once the strobe falls
  p_spd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> !speed_up);

  // R6: speed-up only starts from a strobe rising edge
  p_spd_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speed_up) |-> $past(stb_rise));

  // R9: configuration registers change only on a strobe transfer
  p_cfg_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({b_fields, c_fields, d_fields, e_fields}) |-> $past(stb_rise));

  // R7: mode bits change only on a strobe transfer
  p_mode_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(op_mode) |-> $past(stb_rise));

  // R9: bit counter never runs past its saturation point
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LONG_LEN + 1));
endmodule

bind synth_prog_if synth_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_sync(div_sync),
  .stb_rise(stb_rise), .stb_fall(stb_fall), .cnt(cnt),
  .a_fields(a_fields), .b_fields(b_fields), .c_fields(c_fields),
  .d_fields(d_fields), .e_fields(e_fields), .op_mode(op_mode),
  .speed_up(speed_up)
);

// File: tb/sim_synth_prog_if.sv
module sim_synth_prog_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, div_sync = 1'b0;
  logic [30:0] a_fields;
  logic [19:0] b_fields, c_fields, d_fields, e_fields;
  logic [1:0]  op_mode;
  logic        long_mode, test_route, speed_up;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [30:0] ex_a;
  logic [19:0] ex_b, ex_c, ex_d, ex_e;
  logic        ex_spd;

  always #5 clk = ~clk;

  synth_prog_if u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .div_sync(div_sync), .a_fields(a_fields),
    .b_fields(b_fields), .c_fields(c_fields), .d_fields(d_fields),
    .e_fields(e_fields), .op_mode(op_mode), .long_mode(long_mode),
    .test_route(test_route), .speed_up(speed_up)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    chk("R3 a_fields", {1'b0, a_fields}, {1'b0, ex_a});
    chk("R2 b_fields", {12'd0, b_fields}, {12'd0, ex_b});
    chk("R2 c_fields", {12'd0, c_fields}, {12'd0, ex_c});
    chk("R2 d_fields", {12'd0, d_fields}, {12'd0, ex_d});
    chk("R2 e_fields", {12'd0, e_fields}, {12'd0, ex_e});
    chk("R7 op_mode", {30'd0, op_mode}, {30'd0, ex_c[1:0]});
    chk("R4 long_mode", {31'd0, long_mode}, {31'd0, ex_d[19]});
    chk("R8 test_route", {31'd0, test_route}, {31'd0, ex_e[1:0] == 2'b11});
  endtask

  // reference model built from the requirements
  task automatic model(input logic [31:0] w, input int n, input bit sync);
    ex_spd = 1'b0;
    if (n == 24) begin
      if (!w[23]) begin
        if (!ex_d[19]) begin
          ex_spd = 1'b1;
          if (sync) ex_a = {8'd0, w[22:0]};
        end
      end else begin
        case (w[23:20])
          4'b1000: ex_b = w[19:0];
          4'b1001: ex_c = w[19:0];
          4'b1010: ex_d = w[19:0];
          4'b1111: ex_e = w[19:0];
          default: ;
        endcase
      end
    end else if (n == 32 && ex_d[19] && !w[31]) begin
      ex_spd = 1'b1;
      if (sync) ex_a = w[30:0];
    end
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit sync);
    for (int i = 0; i < n; i++) begin
      ser_data = w[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_strobe = 1'b1;
    model(w, n, sync);
    repeat (3) @(negedge clk);
    div_sync = sync;
    repeat (5) @(negedge clk);
    chk("R6 speed_up during strobe", {31'd0, speed_up}, {31'd0, ex_spd});
    repeat (2) @(negedge clk);
    div_sync = 1'b0;
    ser_strobe = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 speed_up after strobe", {31'd0, speed_up}, 32'd0);
    chk_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    ex_a = '0; ex_b = '0; ex_c = '0; ex_d = '0; ex_e = '0; ex_spd = 1'b0;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 speed_up reset", {31'd0, speed_up}, 32'd0);
    chk_all();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: lowest bit received first lands at bit 0
    send({4'b1000, 20'h00001}, 24, 0);
    // R7: extended mode
    send({4'b1001, 20'h12341}, 24, 0);
    // R8: test routing on, then off
    send({4'b1111, 20'hABCD3}, 24, 0);
    send({4'b1111, 20'hABCD2}, 24, 0);
    // R3: short A with sync, and without sync (R5)
    send({1'b0, 23'h3A5A5A}, 24, 1);
    send({1'b0, 23'h011111}, 24, 0);
    // R9: undefined address and wrong counts
    send({4'b1011, 20'hFFFFF}, 24, 0);
    send({4'b1000, 20'h0F0F0}, 23, 0);
    send({8'h00, 4'b1000, 20'h55555}, 25, 0);
    // R4: long mode on, short A discarded, long A with and without sync
    send({4'b1010, 20'h80000}, 24, 0);
    send({1'b0, 23'h222222}, 24, 1);
    send({1'b0, 31'h7654_3210}, 32, 1);
    send({1'b0, 31'h0123_4567}, 32, 0);
    send({1'b1, 31'h0000_0001}, 32, 1);
    // R4: back to short A words
    send({4'b1010, 20'h00000}, 24, 0);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      int kind;
      r = $urandom;
      kind = $urandom % 7;
      case (kind)
        0: send({8'd0, 4'b1000, r[19:0]}, 24, r[20]);
        1: send({8'd0, 4'b1001, r[19:0]}, 24, r[20]);
        2: send({8'd0, 4'b1010, r[19:0]}, 24, r[20]);
        3: send({8'd0, 4'b1111, r[19:0]}, 24, r[20]);
        4: send({9'd0, r[22:0]}, 24, r[23]);
        5: send({1'b0, r[30:0]}, 32, r[31]);
        default: send(r, 20 + ($urandom % 14), r[0]);
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule